// File: doc/BRIEF.md
# Programmable Reference Divider with Monitor Select

This block divides a stream of reference-clock enables by a ratio chosen by a 4-bit code. It produces a comparison-rate signal for a phase detector in two forms: a pulse one clock wide per comparison period, and a square wave with a 50% duty cycle counted in reference events. The ratio set has two families. When the top code bit is clear, the ratios are powers of two. When it is set, the ratios are three times a power of two. One code in the set is rejected.

Configuration enters through a write strobe. On a strobe the block takes the ratio code and the two monitor control bits. A new ratio waits for the current comparison period to finish, so a change of ratio never produces a short period. A single monitor output can show one of three things, chosen by the two control bits:

- the reference enable stream;
- the comparison square wave;
- nothing, in which case the output is held high.

After reset the monitor shows the comparison square wave.

Top module: `refdiv_top`

## Requirements
- R1: With ratio_code[3]=0, the period between comparison pulses is 2 << ratio_code[2:0] reference events, giving 2 for code 0000 up to 256 for code 0111.
- R2: With ratio_code[3]=1 and ratio_code[2:0] nonzero, the period is 3 << ratio_code[2:0] reference events, giving 6 for code 1001 up to 384 for code 1111.
- R3: A write of code 1000 leaves the active ratio unchanged and sets code_bad on the clock edge that takes the write. The next write of a legal code clears code_bad.
- R4: A new ratio is loaded only when the running count reaches its terminal value. The period that is running when the write arrives completes with the old ratio.
- R5: cmp_pulse goes high for exactly one clock cycle. This happens on the edge after each terminal reference event, and the pulse is never high on two cycles in a row.
- R6: cmp_sq rises together with cmp_pulse. It stays high for exactly half of the reference events of each period.
- R7: The monitor mode is the pair {mon_en, mon_sel} taken on a write, and mon_out is registered:
  - 0x: mon_out is held at 1;
  - 10: mon_out equals the ref_en of the previous cycle;
  - 11: mon_out equals the cmp_sq of the previous cycle.
- R8: Synchronous reset (rst=1) sets the following state:
  - the ratio code is 0000 (ratio 2);
  - the monitor mode is 11;
  - cmp_pulse, cmp_sq and code_bad are 0;
  - mon_out is 1.
- R9: When cfg_wr is 0, ratio_code, mon_en and mon_sel have no effect on the ratio or on the monitor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One reference event per cycle in which it is high |
| cfg_wr | input | 1 | Write strobe for the code and the monitor bits |
| ratio_code | input | 4 | Division ratio code |
| mon_en | input | 1 | Monitor enable; when 0, mon_out is held high |
| mon_sel | input | 1 | Monitor source: 0 for reference, 1 for comparison |
| cmp_pulse | output | 1 | One-cycle comparison pulse per period |
| cmp_sq | output | 1 | Comparison square wave |
| mon_out | output | 1 | Monitor output |
| code_bad | output | 1 | The last code written was the rejected code |

## Verification
Every code is written under three enable patterns:

- **Enable high on every cycle.** This pattern exercises the ratio tables directly.
- **Enable high on every third cycle.** With this pattern, a divider that counted clock cycles instead of reference events gives the wrong period.
- **Pseudo-random enable gaps.** This pattern exposes any half-count or terminal decision that depends on when the events arrive rather than on how many have arrived.

Each write is synchronised just after a comparison pulse. The period that follows shows whether the old ratio was kept until the terminal count (R4), and the periods after that show the new ratio. The monitor is checked cycle by cycle in all four mode settings under the random pattern, where the reference and comparison sources differ in most cycles.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // ratio code layout: top bit picks the family, low bits the shift
    localparam int CODE_W    = 4;
    localparam int STEP_W    = CODE_W - 1;
    localparam int MAX_SHIFT = (1 << STEP_W) - 1;
    localparam int MAX_RATIO = 3 << MAX_SHIFT;
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  ratio_t;

    typedef struct packed {
        logic re;   // monitor enable
        logic rts;  // 1: comparison, 0: reference
    } mon_cfg_t;

    typedef enum logic [1:0] {
        SRC_HIGH = 2'd0,
        SRC_REF  = 2'd1,
        SRC_CMP  = 2'd2
    } mon_src_e;

    function automatic logic code_legal(input code_t c);
        return !(c[CODE_W-1] && (c[STEP_W-1:0] == '0));
    endfunction

    function automatic ratio_t code_ratio(input code_t c);
        ratio_t base;
        base = c[CODE_W-1] ? ratio_t'(3) : ratio_t'(2);
        return base << c[STEP_W-1:0];
    endfunction

    function automatic mon_src_e mon_src(input mon_cfg_t m);
        if (!m.re)
            return SRC_HIGH;
        else if (m.rts)
            return SRC_CMP;
        else
            return SRC_REF;
    endfunction

endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
    import refdiv_pkg::*;
#(
    parameter code_t    RST_CODE = '0,
    parameter mon_cfg_t RST_MON  = '{re: 1'b1, rts: 1'b1}
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_wr,
    input  code_t    code_in,
    input  logic     re_in,
    input  logic     rts_in,
    output code_t    pend_code,
    output mon_cfg_t mon_cfg,
    output logic     code_bad
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_code <= RST_CODE;
            mon_cfg   <= RST_MON;
            code_bad  <= 1'b0;
        end else if (cfg_wr) begin
            mon_cfg <= '{re: re_in, rts: rts_in};
            if (code_legal(code_in)) begin
                pend_code <= code_in;
                code_bad  <= 1'b0;
            end else begin
                code_bad  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_en,
    input  code_t pend_code,
    output logic  cmp_pulse,
    output logic  cmp_sq
);

    localparam ratio_t RST_HALF = code_ratio(RST_CODE) >> 1;

    ratio_t cnt_q, cnt_d;
    ratio_t half_q, half_d;
    ratio_t new_ratio;
    logic   term;

    assign new_ratio = code_ratio(pend_code);
    assign term      = ref_en && (cnt_q == '0);

    // the ratio is sampled only at the terminal event, so periods stay whole
    always_comb begin
        cnt_d  = cnt_q;
        half_d = half_q;
        if (ref_en) begin
            if (term) begin
                cnt_d  = new_ratio - ratio_t'(1);
                half_d = new_ratio >> 1;
            end else begin
                cnt_d  = cnt_q - ratio_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            half_q    <= RST_HALF;
            cmp_pulse <= 1'b0;
            cmp_sq    <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            half_q    <= half_d;
            cmp_pulse <= term;
            cmp_sq    <= (cnt_d >= half_d);
        end
    end

endmodule

// File: rtl/refdiv_monmux.sv
module refdiv_monmux
    import refdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mon_cfg_t mon_cfg,
    input  logic     ref_en,
    input  logic     cmp_sq,
    output logic     mon_out
);

    mon_src_e src;
    logic     mon_d;

    assign src = mon_src(mon_cfg);

    always_comb begin
        unique case (src)
            SRC_REF: mon_d = ref_en;
            SRC_CMP: mon_d = cmp_sq;
            default: mon_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            mon_out <= 1'b1;
        else
            mon_out <= mon_d;
    end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              mon_en,
    input  logic              mon_sel,
    output logic              cmp_pulse,
    output logic              cmp_sq,
    output logic              mon_out,
    output logic              code_bad
);

    code_t    pend_code;
    mon_cfg_t mon_cfg;

    refdiv_cfg #(
        .RST_CODE (RST_CODE)
    ) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .code_in   (ratio_code),
        .re_in     (mon_en),
        .rts_in    (mon_sel),
        .pend_code (pend_code),
        .mon_cfg   (mon_cfg),
        .code_bad  (code_bad)
    );

    refdiv_counter #(
        .RST_CODE (RST_CODE)
    ) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ref_en),
        .pend_code (pend_code),
        .cmp_pulse (cmp_pulse),
        .cmp_sq    (cmp_sq)
    );

    refdiv_monmux mux_i (
        .clk     (clk),
        .rst     (rst),
        .mon_cfg (mon_cfg),
        .ref_en  (ref_en),
        .cmp_sq  (cmp_sq),
        .mon_out (mon_out)
    );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
    import refdiv_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     ref_en,
    input logic     cfg_wr,
    input code_t    ratio_code,
    input logic     cmp_pulse,
    input logic     cmp_sq,
    input logic     mon_out,
    input logic     code_bad,
    input code_t    pend_code,
    input mon_cfg_t mon_cfg
);

    // R3: the rejected code sets the flag and keeps the stored code
    assert_bad_code_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && ratio_code == 4'b1000) |=> (code_bad && $stable(pend_code)));

    // R5: a comparison pulse lasts exactly one clock
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> !cmp_pulse);

    // R6: the square wave starts each period together with the pulse
    assert_sq_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_sq) |-> cmp_pulse);

    assert_pulse_sq_high_R6: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> cmp_sq);

    // R7: monitor modes
    assert_mon_off_R7: assert property (@(posedge clk) disable iff (rst)
        !mon_cfg.re |=> mon_out);

    assert_mon_ref_R7: assert property (@(posedge clk) disable iff (rst)
        (mon_cfg.re && !mon_cfg.rts && !cfg_wr) |=> (mon_out == $past(ref_en)));

    assert_mon_cmp_R7: assert property (@(posedge clk) disable iff (rst)
        (mon_cfg.re && mon_cfg.rts && !cfg_wr) |=> (mon_out == $past(cmp_sq)));

    // R9: without a write the configuration holds
    assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ($stable(pend_code) && $stable(mon_cfg) && $stable(code_bad)));

endmodule

bind refdiv_top refdiv_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ref_en     (ref_en),
    .cfg_wr     (cfg_wr),
    .ratio_code (ratio_code),
    .cmp_pulse  (cmp_pulse),
    .cmp_sq     (cmp_sq),
    .mon_out    (mon_out),
    .code_bad   (code_bad),
    .pend_code  (pend_code),
    .mon_cfg    (mon_cfg)
);

// File: tb/refdiv_top_tb_top.sv
`timescale 1ns/1ps
module refdiv_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_en;
    logic       cfg_wr;
    logic [3:0] ratio_code;
    logic       mon_en;
    logic       mon_sel;
    logic       cmp_pulse;
    logic       cmp_sq;
    logic       mon_out;
    logic       code_bad;

    always #2 clk = ~clk;  // 250 MHz

    refdiv_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .ref_en     (ref_en),
        .cfg_wr     (cfg_wr),
        .ratio_code (ratio_code),
        .mon_en     (mon_en),
        .mon_sel    (mon_sel),
        .cmp_pulse  (cmp_pulse),
        .cmp_sq     (cmp_sq),
        .mon_out    (mon_out),
        .code_bad   (code_bad)
    );

    typedef struct {
        int    r;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    int   ref_mode = 0;
    int   ev_cnt = 0, hi_cnt = 0, last_ev = 0, last_hi = 0;
    logic p_ref = 1'b0, p_sq = 1'b0, prev_pulse = 1'b0;
    int   exp_mode = 2;   // 0 high, 1 reference, 2 comparison
    bit   mon_chk_on = 0;
    int   cur_ratio = 2;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [3:0] c);
        return (c[3] ? 3 : 2) << c[2:0];
    endfunction

    function automatic bit legal(input logic [3:0] c);
        return !(c[3] && c[2:0] == 3'd0);
    endfunction

    // reference enable patterns
    initial begin
        logic [7:0] lfsr = 8'hA5;
        int ph = 0;
        ref_en = 1'b0;
        forever begin
            @(negedge clk);
            case (ref_mode)
                0: ref_en = 1'b1;
                1: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    ref_en = lfsr[0];
                end
                default: begin
                    ref_en = (ph == 0);
                    ph = (ph + 1) % 3;
                end
            endcase
        end
    end

    // event counting at the edge (pre-edge values)
    always @(posedge clk) begin
        if (!rst) begin
            if (ref_en) begin
                ev_cnt++;
                if (cmp_sq) hi_cnt++;
            end
        end
        p_ref = ref_en;
        p_sq  = cmp_sq;
    end

    // monitor: pop expectations at each comparison pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (cmp_pulse) begin
                int meas, hm;
                exp_t e;
                meas = ev_cnt - last_ev;
                hm   = hi_cnt - last_hi;
                last_ev = ev_cnt;
                last_hi = hi_cnt;
                if (q.size() > 0) begin
                    e = q.pop_front();
                    chk(meas == e.r, {e.tag, " period"}, meas, e.r);
                    chk(hm * 2 == e.r, "R6 square high events", hm, e.r / 2);
                    chk(!prev_pulse, "R5 single-cycle pulse", 1, 0);
                end
            end
            if (mon_chk_on) begin
                int ex;
                ex = (exp_mode == 0) ? 1 : (exp_mode == 1) ? int'(p_ref) : int'(p_sq);
                chk(int'(mon_out) == ex, "R7 monitor output", int'(mon_out), ex);
            end
        end
        prev_pulse = cmp_pulse;
    end

    task automatic set_code(input logic [3:0] c);
        int    nr;
        string tg;
        nr = legal(c) ? exp_ratio(c) : cur_ratio;
        tg = !legal(c) ? "R3" : (c[3] ? "R2" : "R1");
        @(negedge clk iff cmp_pulse);
        #1;
        q.push_back('{r: cur_ratio, tag: "R4"});
        ratio_code = c;
        mon_en     = 1'b1;
        mon_sel    = 1'b1;
        cfg_wr     = 1'b1;
        @(negedge clk);
        cfg_wr     = 1'b0;
        chk(code_bad == !legal(c), "R3 code_bad flag", int'(code_bad), int'(!legal(c)));
        @(negedge clk iff cmp_pulse);
        #1;
        repeat (3) q.push_back('{r: nr, tag: tg});
        wait (q.size() == 0);
        cur_ratio = nr;
    endtask

    initial begin
        rst = 1'b1; cfg_wr = 1'b0;
        // junk on the config inputs with no strobe (R9)
        ratio_code = 4'b0111; mon_en = 1'b0; mon_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmp_pulse == 1'b0, "R8 reset cmp_pulse", int'(cmp_pulse), 0);
        chk(cmp_sq == 1'b0, "R8 reset cmp_sq", int'(cmp_sq), 0);
        chk(mon_out == 1'b1, "R8 reset mon_out", int'(mon_out), 1);
        chk(code_bad == 1'b0, "R8 reset code_bad", int'(code_bad), 0);
        rst = 1'b0;

        // defaults: ratio 2 and comparison on the monitor, inputs unstrobed (R8, R9)
        ref_mode = 1;
        @(negedge clk iff cmp_pulse);
        #1;
        repeat (4) q.push_back('{r: 2, tag: "R8 R9 default"});
        exp_mode = 2;
        mon_chk_on = 1;
        wait (q.size() == 0);
        mon_chk_on = 0;

        // every code under three enable patterns (R1 R2 R3 R4)
        for (int pat = 0; pat < 3; pat++) begin
            ref_mode = pat;
            for (int c = 0; c < 16; c++) set_code(4'(c));
        end

        // monitor modes (R7)
        ref_mode = 1;
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            ratio_code = 4'b0010;
            mon_en  = m[1];
            mon_sel = m[0];
            cfg_wr  = 1'b1;
            @(negedge clk);
            cfg_wr  = 1'b0;
            exp_mode = !m[1] ? 0 : (m[0] ? 2 : 1);
            @(negedge clk);
            #1;
            mon_chk_on = 1;
            repeat (40) @(negedge clk);
            #1;
            mon_chk_on = 0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule